// File: doc/BRIEF.md
# Multi-device three-wire serial register master

This block runs single-byte register reads and writes on up to four serial devices. Each device has its own bidirectional data line, and the block exposes that line as separate output, output-enable and input signals so that the pad buffer can sit outside. One shift engine produces a single serial clock and one outgoing bit stream. Every device gets its own copy of them, gated by a per-device select bit in the command word.

A transfer has 24 bits: a 16-bit instruction (a read/write flag, a byte-count field, zero bits and an 8-bit register address), then 8 data bits. On a write the block drives all 24 bits. On a read it drives the instruction, then releases every data line and samples the four return lines in parallel. The requester holds `go` high and waits for the one-cycle `done` pulse. It then reads the four received bytes from one packed word. A 3-bit divider select sets the serial clock rate.

Top module: `tw_spi_hub`

## Requirements
- R1: A synchronous active-high `rst` returns the block to idle from any state: `cs_n` all ones, `sclk` all zeros (the serial clock idles low), `sd_oe` zero, `done` low, `bit_idx` zero and `rx_word` zero.
- R2: A transfer shifts `cmd[23:0]` out MSB first, so `cmd[23]` is the first bit. Every selected device sees exactly 24 rising `sclk` edges.
- R3: With divider select k, each serial clock half period lasts 2^k system cycles. From the clock edge that accepts `go`, `done` is high after exactly 48·2^k further edges.
- R4: `cs_n[i]` is low only while a transfer is active and the select bit `cmd[24+i]` is set. All `cs_n` bits are high in the `done` cycle.
- R5: `sclk[i]` is the shared serial clock ANDed with select bit i. `sd_out[i]` is held at 0 when select bit i is clear, so an unselected device sees no clock edge and no data.
- R6: When `cmd[23]`=0 (write), `sd_oe` is high for all 24 bits. When `cmd[23]`=1 (read), `sd_oe` is high for bit indices 0 to 15 and low from index 16 on. `sd_oe` is low outside a transfer.
- R7: Each device's received byte holds the last 8 `sd_in` values sampled on rising serial clock edges. All four lines are sampled whatever the select bits are. Device i occupies `rx_word[8i+7:8i]`.
- R8: `done` is a single-cycle pulse. If `go` is still high after `done`, no new transfer starts until `go` has been seen low.
- R9: `bit_idx` is 0 when a transfer starts, rises by one at each falling serial clock edge, and equals the number of bits already completed at every rising edge.
- R10: Outgoing data changes only at falling serial clock edges (or at transfer start) and is stable while the serial clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| go | input | 1 | Transfer request level, held until done |
| cmd | input | 32 | Command word: frame in bits 23:0, device selects in 27:24 |
| div_sel | input | 3 | Serial clock divider select |
| done | output | 1 | One-cycle completion pulse, also the write acknowledge |
| bit_idx | output | 5 | Index of the bit currently on the line |
| rx_word | output | 32 | Four received bytes, device 0 in the low byte |
| cs_n | output | 4 | Per-device chip select, active low |
| sclk | output | 4 | Per-device gated serial clock |
| sd_out | output | 4 | Per-device outgoing data |
| sd_oe | output | 4 | Per-device data line output enable |
| sd_in | input | 4 | Per-device incoming data from the pad |

## Verification
The bench builds the block with its default parameters: four devices, a 16-bit instruction, an 8-bit data phase and a 3-bit divider select. These values put the full divider range within reach, from 2-cycle to 256-cycle serial clock periods. They also expose the turnaround at index 16 and every mix of select masks over four lanes, including no device selected at all. A bench-side device model answers reads from per-lane response bytes. While the line is driven it echoes the driven line, so writes and reads both show up in the received word.

// File: rtl/tw_spi_pkg.sv
`timescale 1ns/1ps
package tw_spi_pkg;
    // Sequencer states: waiting, shifting, acknowledging, waiting for go to fall
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_ACK  = 2'd2,
        ST_HOLD = 2'd3
    } seq_state_e;
endpackage

// File: rtl/tw_spi_rate.sv
`timescale 1ns/1ps
// Half-period tick generator: tick every 2^div_sel cycles while run is high.
module tw_spi_rate #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);
    localparam int CNT_W = (1 << DIV_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } rate_t;

    rate_t            r_d, r_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        // 2^div_sel - 1, wrapping to all ones for the largest select
        limit = CNT_W'((CNT_W+1)'(1) << div_sel) - CNT_W'(1);
        tick  = run && (r_q.cnt >= limit);
        r_d   = r_q;
        if (!run || tick) begin
            r_d.cnt = '0;
        end else begin
            r_d.cnt = r_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/tw_spi_seq.sv
`timescale 1ns/1ps
// Shared shift engine: frame shift register, serial clock phase, bit index.
module tw_spi_seq
    import tw_spi_pkg::*;
#(
    parameter int XFER_BITS = 24,
    parameter int IDX_W     = 5,
    parameter int N_DEV     = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 go,
    input  logic                 tick,
    input  logic [XFER_BITS-1:0] frame,
    input  logic [N_DEV-1:0]     sel,
    output logic                 run,
    output logic                 act,
    output logic                 sclk_sh,
    output logic                 mosi,
    output logic                 rnw,
    output logic                 rise,
    output logic                 done,
    output logic [IDX_W-1:0]     idx,
    output logic [N_DEV-1:0]     mask
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(XFER_BITS - 1);

    typedef struct packed {
        seq_state_e           st;
        logic                 act;
        logic                 sclk;
        logic                 rnw;
        logic [XFER_BITS-1:0] sh;
        logic [IDX_W-1:0]     idx;
        logic [N_DEV-1:0]     mask;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        st:   ST_IDLE,
        act:  1'b0,
        sclk: 1'b0,
        rnw:  1'b0,
        sh:   '0,
        idx:  '0,
        mask: '0
    };

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (go) begin
                    s_d.st   = ST_RUN;
                    s_d.act  = 1'b1;
                    s_d.sclk = 1'b0;
                    s_d.sh   = frame;
                    s_d.rnw  = frame[XFER_BITS-1];
                    s_d.idx  = '0;
                    s_d.mask = sel;
                end
            end
            ST_RUN: begin
                if (tick) begin
                    if (!s_q.sclk) begin
                        s_d.sclk = 1'b1;
                    end else begin
                        s_d.sclk = 1'b0;
                        if (s_q.idx == LAST_IDX) begin
                            s_d.st  = ST_ACK;
                            s_d.act = 1'b0;
                            s_d.idx = '0;
                            s_d.sh  = '0;
                        end else begin
                            s_d.idx = s_q.idx + IDX_W'(1);
                            s_d.sh  = {s_q.sh[XFER_BITS-2:0], 1'b0};
                        end
                    end
                end
            end
            ST_ACK: begin
                s_d.st = go ? ST_HOLD : ST_IDLE;
            end
            ST_HOLD: begin
                if (!go) begin
                    s_d.st = ST_IDLE;
                end
            end
            default: s_d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= SEQ_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign run     = (s_q.st == ST_RUN);
    assign act     = s_q.act;
    assign sclk_sh = s_q.sclk;
    assign mosi    = s_q.sh[XFER_BITS-1];
    assign rnw     = s_q.rnw;
    assign rise    = run && tick && !s_q.sclk;
    assign done    = (s_q.st == ST_ACK);
    assign idx     = s_q.idx;
    assign mask    = s_q.mask;
endmodule

// File: rtl/tw_spi_lane.sv
`timescale 1ns/1ps
// One device lane: select gating of clock, data and chip select, plus capture.
module tw_spi_lane #(
    parameter int RX_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            act,
    input  logic            sclk_sh,
    input  logic            mosi,
    input  logic            sel_bit,
    input  logic            drive,
    input  logic            rise,
    input  logic            sd_in,
    output logic            cs_n,
    output logic            sclk,
    output logic            sd_out,
    output logic            sd_oe,
    output logic [RX_W-1:0] rx_byte
);
    typedef struct packed {
        logic [RX_W-1:0] rx;
    } lane_t;

    lane_t l_d, l_q;

    always_comb begin
        l_d = l_q;
        if (rise) begin
            l_d.rx = {l_q.rx[RX_W-2:0], sd_in};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            l_q <= '0;
        end else begin
            l_q <= l_d;
        end
    end

    assign cs_n    = ~(act & sel_bit);
    assign sclk    = sclk_sh & sel_bit;
    assign sd_out  = sel_bit ? mosi : 1'b0;
    assign sd_oe   = drive;
    assign rx_byte = l_q.rx;
endmodule

// File: rtl/tw_spi_hub.sv
`timescale 1ns/1ps
// Multi-device three-wire serial register master.
module tw_spi_hub #(
    parameter int N_DEV      = 4,
    parameter int INSTR_BITS = 16,
    parameter int RX_W       = 8,
    parameter int CMD_W      = 32,
    parameter int DIV_W      = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    go,
    input  logic [CMD_W-1:0]        cmd,
    input  logic [DIV_W-1:0]        div_sel,
    output logic                    done,
    output logic [$clog2(INSTR_BITS+RX_W)-1:0] bit_idx,
    output logic [N_DEV*RX_W-1:0]   rx_word,
    output logic [N_DEV-1:0]        cs_n,
    output logic [N_DEV-1:0]        sclk,
    output logic [N_DEV-1:0]        sd_out,
    output logic [N_DEV-1:0]        sd_oe,
    input  logic [N_DEV-1:0]        sd_in
);
    localparam int XFER_BITS = INSTR_BITS + RX_W;
    localparam int IDX_W     = $clog2(XFER_BITS);
    localparam int SEL_LSB   = XFER_BITS;
    localparam int SEL_TOP   = SEL_LSB + N_DEV;

    logic             tick, run, act, sclk_sh, mosi, rnw, rise, drive;
    logic [IDX_W-1:0] idx;
    logic [N_DEV-1:0] mask;
    logic             unused_cmd_hi;

    assign unused_cmd_hi = ^cmd[CMD_W-1:SEL_TOP];

    tw_spi_rate #(
        .DIV_W (DIV_W)
    ) rate_i (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .div_sel (div_sel),
        .tick    (tick)
    );

    tw_spi_seq #(
        .XFER_BITS (XFER_BITS),
        .IDX_W     (IDX_W),
        .N_DEV     (N_DEV)
    ) seq_i (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .tick    (tick),
        .frame   (cmd[XFER_BITS-1:0]),
        .sel     (cmd[SEL_LSB +: N_DEV]),
        .run     (run),
        .act     (act),
        .sclk_sh (sclk_sh),
        .mosi    (mosi),
        .rnw     (rnw),
        .rise    (rise),
        .done    (done),
        .idx     (idx),
        .mask    (mask)
    );

    // Line is driven for a whole write, or for the instruction part of a read
    assign drive   = act & (~rnw | (idx < IDX_W'(INSTR_BITS)));
    assign bit_idx = idx;

    for (genvar g = 0; g < N_DEV; g++) begin : g_lane
        tw_spi_lane #(
            .RX_W (RX_W)
        ) lane_i (
            .clk     (clk),
            .rst     (rst),
            .act     (act),
            .sclk_sh (sclk_sh),
            .mosi    (mosi),
            .sel_bit (mask[g]),
            .drive   (drive),
            .rise    (rise),
            .sd_in   (sd_in[g]),
            .cs_n    (cs_n[g]),
            .sclk    (sclk[g]),
            .sd_out  (sd_out[g]),
            .sd_oe   (sd_oe[g]),
            .rx_byte (rx_word[g*RX_W +: RX_W])
        );
    end
endmodule

// File: rtl/tw_spi_hub_chk.sv
`timescale 1ns/1ps
// Property checker bound to the top module.
module tw_spi_hub_chk #(
    parameter int N_DEV = 4,
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             done,
    input logic [IDX_W-1:0] bit_idx,
    input logic [N_DEV-1:0] cs_n,
    input logic [N_DEV-1:0] sclk,
    input logic [N_DEV-1:0] sd_out,
    input logic [N_DEV-1:0] sd_oe
);
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_cs_idle_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> (&cs_n));

    p_oe_idle_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> (sd_oe == '0));

    p_clk_gated_r5: assert property (@(posedge clk) disable iff (rst)
        (sclk & cs_n) == '0);

    p_hold_high_r10: assert property (@(posedge clk) disable iff (rst)
        (|sclk) |-> $stable(sd_out));

    p_idx_step_r9: assert property (@(posedge clk) disable iff (rst)
        (bit_idx != $past(bit_idx)) |->
            ((bit_idx == IDX_W'($past(bit_idx) + 1'b1)) || (bit_idx == '0)));
endmodule

bind tw_spi_hub tw_spi_hub_chk #(
    .N_DEV (N_DEV),
    .IDX_W (IDX_W)
) chk_i (
    .clk     (clk),
    .rst     (rst),
    .done    (done),
    .bit_idx (bit_idx),
    .cs_n    (cs_n),
    .sclk    (sclk),
    .sd_out  (sd_out),
    .sd_oe   (sd_oe)
);

// File: tb/tw_spi_hub_tb_top.sv
`timescale 1ns/1ps
module tw_spi_hub_tb_top;
    localparam int N = 4;
    localparam int NV = 7;

    // {cmd, div_sel, response bytes}
    localparam logic [66:0] VEC [NV] = '{
        {32'h010012A5, 3'd0, 32'h00000000},
        {32'h0F808000, 3'd1, 32'h3C5AC3E1},
        {32'h0A00FFFF, 3'd2, 32'h00000000},
        {32'h04800000, 3'd0, 32'h01020380},
        {32'h0000335A, 3'd1, 32'h00000000},
        {32'h09807E00, 3'd3, 32'hFEDCBA98},
        {32'h02004C3D, 3'd7, 32'h00000000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        go = 1'b0;
    logic [31:0] cmd = '0;
    logic [2:0]  div_sel = '0;
    logic        done;
    logic [4:0]  bit_idx;
    logic [31:0] rx_word;
    logic [N-1:0] cs_n, sclk, sd_out, sd_oe, sd_in;
    logic [31:0] resp = '0;
    logic [N-1:0] cur_mask = '0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    tw_spi_hub dut_i (
        .clk(clk), .rst(rst), .go(go), .cmd(cmd), .div_sel(div_sel),
        .done(done), .bit_idx(bit_idx), .rx_word(rx_word),
        .cs_n(cs_n), .sclk(sclk), .sd_out(sd_out), .sd_oe(sd_oe), .sd_in(sd_in)
    );

    // Device model: echo the driven line, answer from resp in the data phase
    always_comb begin
        for (int i = 0; i < N; i++) begin
            if (sd_oe[i]) sd_in[i] = sd_out[i];
            else if (bit_idx >= 5'd16) sd_in[i] = resp[i*8 + (23 - int'(bit_idx))];
            else sd_in[i] = 1'b0;
        end
    end

    // Line monitor sampled at falling system clock edges
    logic [23:0] m_fr [N];
    logic [23:0] m_oe [N];
    int m_rise [N];
    int m_pos [N];
    int m_bad_cs = 0, m_bad_idx = 0, m_bad_hold = 0, m_bad_mask = 0;
    logic [N-1:0] p_sclk = '0, p_sd = '0;

    initial begin
        for (int i = 0; i < N; i++) begin
            m_fr[i] = '0; m_oe[i] = '0; m_rise[i] = 0; m_pos[i] = 0;
        end
    end

    always @(negedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (cs_n[i] && !sclk[i]) m_pos[i] = 0;
            if (sclk[i] && !p_sclk[i]) begin
                m_fr[i] = {m_fr[i][22:0], sd_out[i]};
                m_oe[i] = {m_oe[i][22:0], sd_oe[i]};
                m_rise[i] = m_rise[i] + 1;
                if (cs_n[i]) m_bad_cs = m_bad_cs + 1;
                if (int'(bit_idx) != m_pos[i]) m_bad_idx = m_bad_idx + 1;
                m_pos[i] = m_pos[i] + 1;
            end
            if (sclk[i] && p_sclk[i] && (sd_out[i] != p_sd[i])) m_bad_hold = m_bad_hold + 1;
            if (!cur_mask[i] && (sd_out[i] || sclk[i])) m_bad_mask = m_bad_mask + 1;
        end
        p_sclk = sclk;
        p_sd = sd_out;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL R8 watchdog actual=%0d expected=done", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic run_vec(input logic [31:0] c, input logic [2:0] dv, input logic [31:0] rsp);
        int n;
        int rise0 [N];
        int bcs, bidx, bhold, bmask;
        logic [31:0] exp_rx;
        @(negedge clk);
        cmd = c; div_sel = dv; resp = rsp; cur_mask = c[27:24];
        for (int i = 0; i < N; i++) rise0[i] = m_rise[i];
        bcs = m_bad_cs; bidx = m_bad_idx; bhold = m_bad_hold; bmask = m_bad_mask;
        go = 1'b1;
        n = 0;
        forever begin
            @(posedge clk); n++;
            @(negedge clk);
            if (n == 1) begin
                chk(bit_idx == 5'd0, "R9", "index at start", 32'(bit_idx), 0);
                chk(cs_n == ~c[27:24], "R4", "select at start", 32'(cs_n), 32'(~c[27:24]));
            end
            if (done || n > 20000) break;
        end
        go = 1'b0;
        chk(n == 48 * (1 << dv) + 1, "R3", "cycles to done", n, 48 * (1 << dv) + 1);
        chk(cs_n == 4'hF, "R4", "select at done", 32'(cs_n), 32'hF);
        chk(sd_oe == 4'h0, "R6", "enable at done", 32'(sd_oe), 0);
        @(posedge clk); @(negedge clk); #1;
        chk(done == 1'b0, "R8", "done width", 32'(done), 0);
        exp_rx = '0;
        for (int i = 0; i < N; i++) begin
            chk(m_rise[i] - rise0[i] == (c[24+i] ? 24 : 0), "R2", "rising edges",
                m_rise[i] - rise0[i], c[24+i] ? 24 : 0);
            if (c[24+i]) begin
                chk(m_fr[i] == c[23:0], "R2", "frame bits", 32'(m_fr[i]), 32'(c[23:0]));
                chk(m_oe[i] == (c[23] ? 24'hFFFF00 : 24'hFFFFFF), "R6", "enable per bit",
                    32'(m_oe[i]), c[23] ? 32'hFFFF00 : 32'hFFFFFF);
            end
            exp_rx[i*8 +: 8] = c[23] ? rsp[i*8 +: 8] : (c[24+i] ? c[7:0] : 8'h00);
        end
        chk(m_bad_cs == bcs, "R4", "edge with select high", m_bad_cs - bcs, 0);
        chk(m_bad_idx == bidx, "R9", "index at edges", m_bad_idx - bidx, 0);
        chk(m_bad_hold == bhold, "R10", "data moved while high", m_bad_hold - bhold, 0);
        chk(m_bad_mask == bmask, "R5", "unselected activity", m_bad_mask - bmask, 0);
        chk(rx_word == exp_rx, "R7", "received word", rx_word, exp_rx);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n == 4'hF, "R1", "reset select", 32'(cs_n), 32'hF);
        chk(sclk == 4'h0, "R1", "reset clock", 32'(sclk), 0);
        chk(sd_oe == 4'h0 && done == 1'b0, "R1", "reset enable/done", {sd_oe, 3'b0, done}, 0);
        chk(bit_idx == 5'd0 && rx_word == 32'h0, "R1", "reset index/rx", rx_word, 0);
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            run_vec(VEC[v][66:35], VEC[v][34:32], VEC[v][31:0]);
        end

        // R8: go still held after done must not restart
        @(negedge clk);
        cmd = 32'h010012A5; div_sel = 3'd0; cur_mask = 4'h1; go = 1'b1;
        for (int k = 0; k < 2000 && !done; k++) @(negedge clk);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk(done == 1'b0 && cs_n == 4'hF, "R8", "held go restart",
                {27'b0, done, cs_n}, 32'hF);
        end
        go = 1'b0;
        @(negedge clk);
        run_vec(32'h0F800000, 3'd0, 32'hA1B2C3D4);

        // R1: reset in the middle of a read
        @(negedge clk);
        cmd = 32'h0F801100; div_sel = 3'd1; cur_mask = 4'hF; go = 1'b1;
        repeat (30) @(negedge clk);
        chk(cs_n == 4'h0, "R4", "mid-transfer select", 32'(cs_n), 0);
        rst = 1'b1; go = 1'b0;
        @(negedge clk);
        chk(cs_n == 4'hF && sclk == 4'h0, "R1", "mid reset lines", {cs_n, sclk}, 32'hF0);
        chk(sd_oe == 4'h0 && done == 1'b0, "R1", "mid reset enable", 32'(sd_oe), 0);
        chk(bit_idx == 5'd0 && rx_word == 32'h0, "R1", "mid reset rx", rx_word, 0);
        rst = 1'b0;
        cur_mask = 4'h0;
        run_vec(32'h05003377, 3'd2, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule